// File: doc/BRIEF.md
# Trigger History Recorder and Replayer

This block keeps a running history of three timing events: trigger, bunch-counter reset and event-counter reset. It stores them in a large external synchronous SRAM that works as a circular buffer of 16-bit words. Each stored word carries the events that happened in one clock, together with the number of clocks since the word before it. Quiet stretches longer than the gap field can hold are bridged by filler words. A busy or freeze input stops recording at once, so the history that led up to the busy condition stays in memory.

Later the same history can be replayed. Replay starts with the oldest surviving word. For each word the block counts down its gap and then pulses the stored events on three outputs for one clock, so the original spacing comes back out. The SRAM is pipelined and returns read data two clocks after the address. A small prefetch queue hides that latency, so back-to-back events one clock apart replay at full rate.

A register port carries the mode commands and the status. It also gives the host word-by-word readout of the buffer. Recording and replay never run together, and a new mode is accepted only from idle.

Top module: `trig_seq_recorder`

## Requirements
- R1: While recording, every stored word has the flags in bits [15:13], with bit 15 = event-counter reset, bit 14 = bunch-counter reset and bit 13 = trigger, and the gap in bits [12:0]. A word is written at the write pointer, which then advances by one.
- R2: A word is written in any recording clock in which at least one event input is high. Its gap is the number of clocks since the previous word. For the first word after recording starts, the gap counts from the first recording clock, which counts as 0.
- R3: If 8191 clocks pass with no word written, a filler word is written with flags 000 and gap 8191.
- R4: The write pointer wraps from the last address to 0. Status bit 2 (wrapped) is set when that first wrap happens and is cleared when recording starts.
- R5: A high freeze input during recording stops recording in that clock. Nothing is stored in that clock, the mode returns to idle and status bit 3 (frozen) is set.
- R6: Replay starts at the oldest word. That is the write pointer if the buffer has wrapped, and address 0 otherwise.
- R7: In replay, the first word's flags appear on the outputs 4 + max(gap, 1) clocks after the edge that accepts the command. Each later word appears its own gap later, and every pulse lasts exactly one clock. Filler words pulse nothing.
- R8: After the last word of a replay, the mode returns to idle one clock later. An empty buffer returns to idle one clock after the command.
- R9: Register 0 accepts commands: 1 starts recording and 2 starts replay, and both are honoured only when idle with no SRAM read in flight. Writing 0 stops the current mode, and any other write while not idle is ignored. Reading register 0 gives bits [1:0] as the mode (0 idle, 1 record, 2 replay), plus wrapped and frozen. Reading register 1 gives the write pointer.
- R10: Writing an address to register 2 while idle reads that SRAM word. From 2 clocks after the write edge onward, reading register 2 returns the word.
- R11: The SRAM data bus is driven only during a write, and the write enable and read strobe are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_trig | input | 1 | Trigger occurrence |
| ev_bcr | input | 1 | Bunch-counter reset occurrence |
| ev_ecr | input | 1 | Event-counter reset occurrence |
| freeze | input | 1 | Busy condition that halts recording |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data (combinational) |
| pb_trig | output | 1 | Replayed trigger pulse |
| pb_bcr | output | 1 | Replayed bunch-counter reset pulse |
| pb_ecr | output | 1 | Replayed event-counter reset pulse |
| sram_addr | output | AW | SRAM address |
| sram_dq | inout | 16 | SRAM bidirectional data |
| sram_we | output | 1 | SRAM write enable, active high |
| sram_rd | output | 1 | SRAM read strobe, active high |

## Verification
The bench goes after runs of events one clock apart. If the prefetch fell behind, the replayed spacing would stretch. It also tests an event in the very first recording clock, where a gap of 0 must still replay with the fixed start latency. A long quiet stretch has to produce a filler word at exactly 8191 clocks; getting that wrong would shift every later event on replay. Further checks cover a buffer that wraps, which must replay from the overwritten point and not from address 0, and a freeze that arrives in the same clock as an event, whose event must be lost. Mode commands sent while recording or replaying are checked to change nothing, and replay of an empty buffer must come straight back to idle.

// File: rtl/trig_seq_recorder.sv
module trig_seq_recorder #(
  parameter int AW = 22,
  parameter int GW = 13,
  parameter int FW = 3,
  parameter int RW = 32,
  parameter int PF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_trig,
  input  logic          ev_bcr,
  input  logic          ev_ecr,
  input  logic          freeze,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          pb_trig,
  output logic          pb_bcr,
  output logic          pb_ecr,
  output logic [AW-1:0] sram_addr,
  inout  wire  [FW+GW-1:0] sram_dq,
  output logic          sram_we,
  output logic          sram_rd
);
  localparam int DW  = FW + GW;
  localparam int PFW = $clog2(PF);
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};
  localparam logic [1:0] M_IDLE = 2'd0, M_REC = 2'd1, M_PLAY = 2'd2;

  logic [1:0]    mode;
  logic [AW-1:0] wp, rp;
  logic          wrapped, frozen;
  logic [GW-1:0] gap, rem;
  logic [1:0]    rv, rtag;
  logic [AW:0]   total, issued, fired;
  logic [DW-1:0] pf [PF];
  logic [PFW-1:0] ph, pt;
  logic [PFW:0]  pcnt;
  logic          cur_v;
  logic [FW-1:0] cur_f, pout;
  logic [DW-1:0] hword;

  wire [FW-1:0] ev      = {ev_ecr, ev_bcr, ev_trig};
  wire          quiet   = (mode == M_IDLE) && (rv == 2'b00);
  wire          ctl_wr  = reg_wr && (reg_addr == 2'd0);
  wire          host_rd = reg_wr && (reg_addr == 2'd2) && quiet;
  wire          rec_wr  = (mode == M_REC) && !freeze && ((ev != '0) || (gap == GMAX));
  wire [PFW+1:0] occ    = {1'b0, pcnt} + (PFW+2)'(rv[0]) + (PFW+2)'(rv[1]);
  wire          issue   = (mode == M_PLAY) && (issued != total) && (occ < (PFW+2)'(PF));
  wire          fire    = (mode == M_PLAY) && cur_v && (rem <= GW'(1));
  wire          pop     = (mode == M_PLAY) && (pcnt != '0) && (!cur_v || fire);
  wire          push    = (mode == M_PLAY) && rv[1] && !rtag[1];
  wire [DW-1:0] head    = pf[ph];
  wire          unused_wdata = &{1'b0, reg_wdata};

  assign sram_we   = rec_wr;
  assign sram_rd   = issue || host_rd;
  assign sram_addr = (mode == M_REC) ? wp : (mode == M_PLAY) ? rp : reg_wdata[AW-1:0];
  assign sram_dq   = rec_wr ? {ev, gap} : {DW{1'bz}};
  assign {pb_ecr, pb_bcr, pb_trig} = pout;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = RW'({frozen, wrapped, mode});
      2'd1:    reg_rdata = RW'(wp);
      2'd2:    reg_rdata = RW'(hword);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) pf[pt] <= sram_dq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE; wp <= '0; rp <= '0; wrapped <= 1'b0; frozen <= 1'b0;
      gap <= '0; rem <= '0; rv <= '0; rtag <= '0;
      total <= '0; issued <= '0; fired <= '0;
      ph <= '0; pt <= '0; pcnt <= '0;
      cur_v <= 1'b0; cur_f <= '0; pout <= '0; hword <= '0;
    end else begin
      rv   <= {rv[0], sram_rd};
      rtag <= {rtag[0], host_rd};
      if (rv[1] && rtag[1]) hword <= sram_dq;
      pout <= fire ? cur_f : '0;

      if (rec_wr) begin
        wp  <= wp + 1'b1;
        gap <= GW'(1);
        if (&wp) wrapped <= 1'b1;
      end else if (mode == M_REC) begin
        gap <= gap + 1'b1;
      end

      if (issue) begin
        rp     <= rp + 1'b1;
        issued <= issued + 1'b1;
      end
      if (push) pt <= pt + 1'b1;
      if (pop)  ph <= ph + 1'b1;
      pcnt <= pcnt + (PFW+1)'(push) - (PFW+1)'(pop);

      if (pop) begin
        cur_v <= 1'b1;
        cur_f <= head[DW-1:GW];
        rem   <= head[GW-1:0];
      end else if (fire) begin
        cur_v <= 1'b0;
      end else if (cur_v) begin
        rem <= rem - 1'b1;
      end
      if (fire) fired <= fired + 1'b1;

      case (mode)
        M_IDLE: if (ctl_wr && quiet) begin
          if (reg_wdata[1:0] == M_REC) begin
            mode <= M_REC; wp <= '0; wrapped <= 1'b0; frozen <= 1'b0; gap <= '0;
          end else if (reg_wdata[1:0] == M_PLAY) begin
            mode   <= M_PLAY;
            rp     <= wrapped ? wp : '0;
            total  <= wrapped ? {1'b1, {AW{1'b0}}} : {1'b0, wp};
            issued <= '0; fired <= '0;
            ph <= '0; pt <= '0; pcnt <= '0; cur_v <= 1'b0;
          end
        end
        M_REC: begin
          if (freeze) begin
            mode <= M_IDLE; frozen <= 1'b1;
          end else if (ctl_wr && reg_wdata[1:0] == 2'd0) begin
            mode <= M_IDLE;
          end
        end
        M_PLAY: if (fired == total || (ctl_wr && reg_wdata[1:0] == 2'd0)) mode <= M_IDLE;
        default: mode <= M_IDLE;
      endcase
    end
  end

  a_r5_freeze_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_REC && freeze) |=> (mode == M_IDLE && frozen));

  a_r11_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> !sram_rd);

  a_r4_wrap_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrapped) |-> ($past(wp) == {AW{1'b1}} && $past(sram_we)));

  a_r7_pulse_only_in_replay: assert property (@(posedge clk) disable iff (!rst_n)
    (pout != '0) |-> ($past(mode) == M_PLAY));

  a_r9_mode_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) != M_IDLE && mode != M_IDLE) |-> (mode == $past(mode)));

  a_r7_prefetch_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= (PFW+1)'(PF));
endmodule

// File: tb/trig_seq_recorder_tb.sv
`timescale 1ns/1ps
module trig_seq_recorder_tb;
  localparam int AW = 6;
  localparam int DEP = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_trig = 0, ev_bcr = 0, ev_ecr = 0, freeze = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic pb_trig, pb_bcr, pb_ecr, sram_we, sram_rd;
  logic [AW-1:0] sram_addr;
  wire [15:0] dq;

  always #5 clk = ~clk;

  trig_seq_recorder #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_trig(ev_trig), .ev_bcr(ev_bcr), .ev_ecr(ev_ecr),
    .freeze(freeze), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pb_trig(pb_trig), .pb_bcr(pb_bcr), .pb_ecr(pb_ecr),
    .sram_addr(sram_addr), .sram_dq(dq), .sram_we(sram_we), .sram_rd(sram_rd));

  // behavioural pipelined SRAM, two-clock read latency
  logic [15:0] sram [DEP];
  logic [15:0] q1 = 0, q2 = 0;
  logic v1 = 0, v2 = 0;
  initial for (int i = 0; i < DEP; i++) sram[i] = '0;
  always @(posedge clk) begin
    if (sram_we) sram[sram_addr] <= dq;
    q1 <= sram[sram_addr]; v1 <= sram_rd;
    q2 <= q1; v2 <= v1;
  end
  assign dq = v2 ? q2 : 16'hzzzz;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0, errors = 0;
  string tag = "R9";
  logic [1:0] raddr = 0;

  // reference model
  int mmode = 0, mwp = 0, mgap = 0, play_end = -1, h_ready = -1;
  logic mwrapped = 0, mfrozen = 0;
  logic [15:0] mmem [DEP];
  logic [15:0] mh = 0;
  int qt[$];
  logic [2:0] qf[$];
  initial for (int i = 0; i < DEP; i++) mmem[i] = '0;

  task automatic fail(string what, int act, int exp);
    errors++;
    $display("FAIL %s %s act=%0h exp=%0h cyc=%0d", tag, what, act, exp, cyc);
  endtask

  task automatic check();
    logic [2:0] ex;
    ex = '0;
    if (qt.size() > 0 && qt[0] == cyc) begin
      ex = qf[0]; void'(qt.pop_front()); void'(qf.pop_front());
    end
    vectors++;
    if ({pb_ecr, pb_bcr, pb_trig} !== ex) fail("replay", int'({pb_ecr, pb_bcr, pb_trig}), int'(ex));
    case (reg_addr)
      2'd0: if (reg_rdata !== {28'd0, mfrozen, mwrapped, 2'(mmode)})
              fail("status", int'(reg_rdata), int'({mfrozen, mwrapped, 2'(mmode)}));
      2'd1: if (reg_rdata !== 32'(mwp)) fail("wptr", int'(reg_rdata), mwp);
      2'd2: if (h_ready >= 0 && cyc >= h_ready && reg_rdata !== {16'd0, mh})
              fail("readout", int'(reg_rdata), int'(mh));
      default: ;
    endcase
  endtask

  task automatic model(logic [2:0] f, logic fz, logic wr, logic [1:0] a, logic [31:0] d);
    int e, n, s, t, g;
    e = cyc + 1;
    case (mmode)
      1: begin
        if (fz) begin mmode = 0; mfrozen = 1; end
        else begin
          if (f != 0 || mgap == 8191) begin
            mmem[mwp] = {f, 13'(mgap)};
            if (mwp == DEP-1) mwrapped = 1;
            mwp = (mwp + 1) % DEP; mgap = 1;
          end else mgap++;
          if (wr && a == 0 && d[1:0] == 0) mmode = 0;
        end
      end
      0: begin
        if (wr && a == 0 && d[1:0] == 1) begin
          mmode = 1; mwp = 0; mwrapped = 0; mfrozen = 0; mgap = 0;
        end else if (wr && a == 0 && d[1:0] == 2) begin
          mmode = 2;
          n = mwrapped ? DEP : mwp;
          s = mwrapped ? mwp : 0;
          t = e;
          for (int i = 0; i < n; i++) begin
            g = int'(mmem[(s+i)%DEP][12:0]);
            if (i == 0) t = e + 4 + ((g < 1) ? 1 : g); else t = t + g;
            qt.push_back(t); qf.push_back(mmem[(s+i)%DEP][15:13]);
          end
          play_end = t + 1;
        end
        if (wr && a == 2) begin mh = mmem[d[AW-1:0]]; h_ready = e + 2; end
      end
      default: begin
        if (wr && a == 0 && d[1:0] == 0) begin
          mmode = 0;
          while (qt.size() > 0 && qt[qt.size()-1] > e) begin
            void'(qt.pop_back()); void'(qf.pop_back());
          end
        end else if (e == play_end) mmode = 0;
      end
    endcase
  endtask

  task automatic step(logic [2:0] f, logic fz, logic wr, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    check();
    {ev_ecr, ev_bcr, ev_trig} = f; freeze = fz;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    model(f, fz, wr, a, d);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) step(3'b000, 1'b0, 1'b0, raddr, 32'd0);
  endtask

  task automatic ev_after(int n, logic [2:0] f);
    tick(n);
    step(f, 1'b0, 1'b0, raddr, 32'd0);
  endtask

  task automatic cmd(int v);
    step(3'b000, 1'b0, 1'b1, 2'd0, 32'(v));
    raddr = 0;
  endtask

  task automatic host_read(int adr);
    step(3'b000, 1'b0, 1'b1, 2'd2, 32'(adr));
    raddr = 2;
    tick(4);
    raddr = 0;
  endtask

  task automatic run_replay();
    int lim;
    cmd(2);
    lim = 0;
    while (mmode != 0 && lim < 40000) begin tick(1); lim++; end
    tick(4);
  endtask

  initial begin
    #1900000;
    errors++;
    $display("FAIL watchdog expired cyc=%0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R9"; tick(2);                 // reset state: idle, pointer 0
    raddr = 1; tick(1); raddr = 0;

    // R1 R2: record events, including one in the first clock and back-to-back
    tag = "R2";
    cmd(1);
    ev_after(0, 3'b001);
    ev_after(0, 3'b010);
    ev_after(3, 3'b101);
    ev_after(5, 3'b111);
    ev_after(1, 3'b001);
    ev_after(0, 3'b100);
    tag = "R9"; cmd(2); tick(3);         // ignored while recording
    raddr = 1; tick(2); raddr = 0;
    cmd(0); tick(3);
    tag = "R1";
    for (int i = 0; i < 6; i++) host_read(i);   // R10 readout, R11 bus turnaround
    tag = "R7";
    run_replay();

    // R8: a start command issued during replay is ignored, replay completes
    tag = "R8";
    cmd(2);
    tick(2);
    step(3'b000, 1'b0, 1'b1, 2'd0, 32'd1);
    while (mmode != 0) tick(1);
    tick(4);

    // R3: long quiet stretch produces a filler word
    tag = "R3";
    cmd(1);
    ev_after(9000, 3'b010);
    ev_after(2, 3'b001);
    cmd(0); tick(3);
    host_read(0); host_read(1); host_read(2);
    run_replay();

    // R4 R6: wrap around, replay from oldest surviving word
    tag = "R4";
    cmd(1);
    for (int i = 0; i < DEP + 6; i++) ev_after(i % 3, 3'(1 + (i % 7)));
    raddr = 1; tick(2); raddr = 0; tick(1);
    cmd(0); tick(3);
    host_read(0);
    tag = "R6";
    run_replay();

    // R5: freeze in the same clock as an event drops that event
    tag = "R5";
    cmd(1);
    ev_after(2, 3'b001);
    tick(3);
    step(3'b011, 1'b1, 1'b0, 2'd0, 32'd0);
    tick(3);
    raddr = 1; tick(2); raddr = 0;
    host_read(1);
    run_replay();

    // R8: empty buffer returns straight to idle
    tag = "R8";
    cmd(1);
    cmd(0); tick(3);
    run_replay();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule